// File: doc/BRIEF.md
# Countdown Watchdog with Byte Control Register

This block is a watchdog timer that sits behind a small register window. A 16-bit live counter counts down by one on each pulse of an external 10 ms prescaler tick while the watchdog is enabled. Software first writes a timeout value into a holding register. It then writes the control byte with the enable and reload bits set, which arms the timer. Writing the reload bit again while the timer runs refreshes the countdown; no other keep-alive sequence exists. The count register reads back the live number of ticks left.

When an enabled tick takes the counter from one to zero, the block sets a sticky warning bit in the control byte. If the interrupt-enable bit is set, it issues a single-cycle non-maskable interrupt pulse. Otherwise it raises a reset request that stays high until the next reset. To force an immediate restart, software loads a count of one and reloads; the next tick then expires the timer.

Top module: `wdt_top`

## Requirements
- R1: After reset the live counter and holding register read 0, the control byte reads 0x00, and `nmi_pulse` and `rst_req` are low.
- R2: A write to offset 0x10 stores `wdata[15:0]` in the holding register only; the live counter keeps its value until a reload.
- R3: A write to offset 0x16 with bit 2 set copies the holding register into the live counter on that clock edge; bit 2 always reads back as 0.
- R4: While enabled (control bit 0 = 1), the counter decrements by exactly one per clock in which `tick` is high, does not change without a tick, and stays at 0 rather than wrapping.
- R5: With bit 0 cleared, ticks leave the counter unchanged, and the interrupt-enable bit (bit 3) keeps the value last written.
- R6: An enabled tick at count 1 sets the warning bit (bit 7). The bit stays set through control writes that carry 0 in bit 7 and is cleared by writing 1 to bit 7.
- R7: With bit 3 set, an expiry drives `nmi_pulse` high for exactly one cycle, starting at the edge that zeroes the counter, and leaves `rst_req` low.
- R8: With bit 3 clear, an expiry raises `rst_req` at the edge that zeroes the counter. It then holds `rst_req` high until reset, even after the warning bit is cleared.
- R9: When a reload write and a tick fall in the same cycle, the reload wins: the counter takes the holding value and no expiry occurs.
- R10: `rdata` shows the live counter when `addr` is 0x10, and the control byte {warn, 000, irq_en, 0, 0, en} when `addr` is 0x16. Any other address reads 0.
- R11: Loading 1 into the holding register and then writing enable+reload makes the very next tick expire the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 5 | Byte offset of the register window |
| wdata | input | 16 | Write data; the control register uses bits 7:0 |
| rdata | output | 16 | Combinational read data for `addr` |
| tick | input | 1 | Single-cycle 10 ms prescaler pulse |
| nmi_pulse | output | 1 | One-cycle interrupt pulse on expiry |
| rst_req | output | 1 | Sticky system reset request on expiry |

## Verification
The assertions assume that `tick` comes from an external prescaler as a clean, synchronous pulse, and that a reload arrives only through a control write. A counter that does not grow is therefore an invariant except in cycles with a reload write. The stimulus keeps to these assumptions. Every tick lasts one clock. Every reload goes through a full control write on `wr_en`. Random tick density and random refresh timing are driven against a bench model, so that expiries, refreshes and reload-versus-tick collisions all occur inside the legal input space.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W     = 16;
  localparam int ADDR_W    = 5;
  localparam int BIT_EN    = 0;
  localparam int BIT_RLD   = 2;
  localparam int BIT_IRQEN = 3;
  localparam int BIT_WARN  = 7;

  typedef struct packed {
    logic warn;
    logic irq_en;
    logic en;
  } ctrl_t;

  function automatic logic [7:0] pack_ctrl(input ctrl_t c);
    logic [7:0] b;
    b = 8'h00;
    b[BIT_EN]    = c.en;
    b[BIT_IRQEN] = c.irq_en;
    b[BIT_WARN]  = c.warn;
    return b;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 5,
  parameter logic [AW-1:0] CNT_OFS  = 5'h10,
  parameter logic [AW-1:0] CTRL_OFS = 5'h16
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic          expire,
  input  logic [CW-1:0] live_cnt,
  output logic [CW-1:0] hold,
  output ctrl_t         ctrl,
  output logic          reload_stb,
  output logic [15:0]   rdata
);
  logic          wr_cnt, wr_ctrl;
  logic [CW-1:0] hold_d;
  ctrl_t         ctrl_d;

  assign wr_cnt     = wr_en && (addr == CNT_OFS);
  assign wr_ctrl    = wr_en && (addr == CTRL_OFS);
  assign reload_stb = wr_ctrl && wdata[BIT_RLD];

  always_comb begin
    hold_d = hold;
    if (wr_cnt) hold_d = wdata[CW-1:0];
  end

  always_comb begin
    ctrl_d = ctrl;
    if (wr_ctrl) begin
      ctrl_d.en     = wdata[BIT_EN];
      ctrl_d.irq_en = wdata[BIT_IRQEN];
      if (wdata[BIT_WARN]) ctrl_d.warn = 1'b0;
    end
    if (expire) ctrl_d.warn = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold <= '0;
      ctrl <= '0;
    end else begin
      if (wr_cnt)            hold <= hold_d;
      if (wr_ctrl || expire) ctrl <= ctrl_d;
    end
  end

  always_comb begin
    rdata = 16'h0000;
    if (addr == CNT_OFS)       rdata[CW-1:0] = live_cnt;
    else if (addr == CTRL_OFS) rdata[7:0]    = pack_ctrl(ctrl);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          reload_stb,
  input  logic [CW-1:0] hold,
  output logic [CW-1:0] cnt,
  output logic          expire
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          step;
  logic          load_en;
  logic [CW-1:0] cnt_d;

  assign step   = en && tick && (cnt != '0) && !reload_stb;
  assign expire = step && (cnt == ONE);

  always_comb begin
    cnt_d   = cnt;
    load_en = 1'b0;
    if (reload_stb) begin
      cnt_d   = hold;
      load_en = 1'b1;
    end else if (step) begin
      cnt_d   = cnt - ONE;
      load_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      cnt <= '0;
    else if (load_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry (
  input  logic clk,
  input  logic arst_n,
  input  logic expire,
  input  logic irq_en,
  output logic nmi_pulse,
  output logic rst_req
);
  logic nmi_d, rst_d;

  always_comb begin
    nmi_d = expire && irq_en;
    rst_d = rst_req || (expire && !irq_en);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      nmi_pulse <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      nmi_pulse <= nmi_d;
      rst_req   <= rst_d;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_WIDTH  = CNT_W,
  parameter int ADDR_WIDTH = ADDR_W,
  parameter logic [ADDR_WIDTH-1:0] CNT_OFS  = 5'h10,
  parameter logic [ADDR_WIDTH-1:0] CTRL_OFS = 5'h16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_WIDTH-1:0] addr,
  input  logic [15:0]           wdata,
  output logic [15:0]           rdata,
  input  logic                  tick,
  output logic                  nmi_pulse,
  output logic                  rst_req
);
  logic [1:0]           rst_sync;
  logic                 arst_n;
  logic [CNT_WIDTH-1:0] hold;
  logic [CNT_WIDTH-1:0] live_cnt;
  ctrl_t                ctrl;
  logic                 reload_stb;
  logic                 expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign arst_n = rst_sync[1];

  wdt_regs #(
    .CW(CNT_WIDTH), .AW(ADDR_WIDTH), .CNT_OFS(CNT_OFS), .CTRL_OFS(CTRL_OFS)
  ) u_regs (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire(expire), .live_cnt(live_cnt), .hold(hold), .ctrl(ctrl),
    .reload_stb(reload_stb), .rdata(rdata)
  );

  wdt_counter #(.CW(CNT_WIDTH)) u_cnt (
    .clk(clk), .arst_n(arst_n), .tick(tick), .en(ctrl.en),
    .reload_stb(reload_stb), .hold(hold), .cnt(live_cnt), .expire(expire)
  );

  wdt_expiry u_exp (
    .clk(clk), .arst_n(arst_n), .expire(expire), .irq_en(ctrl.irq_en),
    .nmi_pulse(nmi_pulse), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          arst_n,
  input logic          rld,
  input logic          en,
  input logic          warn,
  input logic [CW-1:0] cnt,
  input logic          nmi_pulse,
  input logic          rst_req
);
  // R4: without a reload the counter never grows
  assert_no_growth_R4: assert property (@(posedge clk) disable iff (!arst_n)
    !rld |=> (cnt <= $past(cnt)));
  // R4: zero holds without a reload
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (cnt == '0 && !rld) |=> (cnt == '0));
  // R5: disabled counter is frozen
  assert_frozen_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (!en && !rld) |=> $stable(cnt));
  // R7: interrupt pulse lasts one cycle
  assert_nmi_single_R7: assert property (@(posedge clk) disable iff (!arst_n)
    nmi_pulse |=> !nmi_pulse);
  // R6: interrupt pulse comes with the warning flag
  assert_nmi_warn_R6: assert property (@(posedge clk) disable iff (!arst_n)
    nmi_pulse |-> warn);
  // R8: reset request is sticky
  assert_rst_sticky_R8: assert property (@(posedge clk) disable iff (!arst_n)
    rst_req |=> rst_req);
  // R8: reset request rises only with the counter at zero
  assert_rst_at_zero_R8: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_req) |-> (cnt == '0 && warn));
endmodule

bind wdt_top wdt_chk #(.CW(CNT_WIDTH)) u_chk (
  .clk(clk), .arst_n(arst_n), .rld(reload_stb), .en(ctrl.en), .warn(ctrl.warn),
  .cnt(live_cnt), .nmi_pulse(nmi_pulse), .rst_req(rst_req)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam logic [4:0] A_CNT  = 5'h10;
  localparam logic [4:0] A_CTRL = 5'h16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = A_CNT;
  logic [15:0] wdata = 16'h0;
  logic        tick = 1'b0;
  logic [15:0] rdata;
  logic        nmi_pulse, rst_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdt_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
              .rdata(rdata), .tick(tick), .nmi_pulse(nmi_pulse), .rst_req(rst_req));

  function automatic logic [15:0] ctrl_val(input bit en, input bit irq, input bit warn);
    return {8'h00, warn, 3'b000, irq, 2'b00, en};
  endfunction

  function automatic logic [15:0] next_cnt(input logic [15:0] c, input bit en, input bit t);
    return (en && t && c != 16'h0) ? c - 16'h1 : c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] exp;
    logic        exp_nmi, was_ctrl;
    void'($urandom(32'd7));

    do_reset();
    rd(A_CNT, v);  chk("R1 count", v, 16'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0);
    chk("R1 nmi", {15'h0, nmi_pulse}, 16'h0);
    chk("R1 rst_req", {15'h0, rst_req}, 16'h0);

    wr(A_CNT, 16'd5);
    rd(A_CNT, v); chk("R2 hold only", v, 16'd0);
    wr(A_CTRL, 16'h000D);
    rd(A_CNT, v);  chk("R3 reload", v, 16'd5);
    rd(A_CTRL, v); chk("R3 R10 ctrl readback", v, ctrl_val(1, 1, 0));

    pulse_tick();
    rd(A_CNT, v); chk("R4 one tick", v, 16'd4);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); chk("R4 no tick", v, 16'd4);

    wr(A_CTRL, 16'h0008);
    repeat (3) pulse_tick();
    rd(A_CNT, v);  chk("R5 frozen", v, 16'd4);
    rd(A_CTRL, v); chk("R5 irq kept", v, ctrl_val(0, 1, 0));

    wr(A_CTRL, 16'h0009);
    repeat (3) pulse_tick();
    rd(A_CNT, v); chk("R4 count to 1", v, 16'd1);
    pulse_tick();
    chk("R7 nmi high", {15'h0, nmi_pulse}, 16'h1);
    rd(A_CNT, v);  chk("R6 count zero", v, 16'd0);
    rd(A_CTRL, v); chk("R6 warn set", v, ctrl_val(1, 1, 1));
    @(negedge clk);
    chk("R7 nmi one cycle", {15'h0, nmi_pulse}, 16'h0);
    repeat (2) pulse_tick();
    rd(A_CNT, v); chk("R4 no wrap", v, 16'd0);
    chk("R7 no rst_req", {15'h0, rst_req}, 16'h0);

    wr(A_CTRL, 16'h0009);
    rd(A_CTRL, v); chk("R6 warn kept", v, ctrl_val(1, 1, 1));
    wr(A_CTRL, 16'h0089);
    rd(A_CTRL, v); chk("R6 warn cleared", v, ctrl_val(1, 1, 0));

    wr(A_CNT, 16'd7);
    @(negedge clk);
    wr_en = 1'b1; addr = A_CTRL; wdata = 16'h000D; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd(A_CNT, v); chk("R9 reload wins", v, 16'd7);
    rd(5'h00, v); chk("R10 unmapped", v, 16'h0);

    wr(A_CNT, 16'd1);
    wr(A_CTRL, 16'h0005);
    pulse_tick();
    chk("R11 R8 rst_req", {15'h0, rst_req}, 16'h1);
    chk("R8 no nmi", {15'h0, nmi_pulse}, 16'h0);
    rd(A_CTRL, v); chk("R11 warn", v, ctrl_val(1, 0, 1));
    wr(A_CTRL, 16'h0080);
    repeat (4) @(negedge clk);
    chk("R8 held", {15'h0, rst_req}, 16'h1);
    do_reset();
    chk("R1 R8 cleared by reset", {15'h0, rst_req}, 16'h0);

    // random phase: refresh and tick timing against a model
    wr(A_CNT, 16'd12);
    wr(A_CTRL, 16'h000D);
    exp = 16'd12; exp_nmi = 1'b0; was_ctrl = 1'b0;
    addr = A_CNT;
    for (int i = 0; i < 3000; i++) begin
      bit do_rld, t;
      @(negedge clk);
      #1;
      if (!was_ctrl) chk("R4 random count", rdata, exp);
      chk("R7 random nmi", {15'h0, nmi_pulse}, {15'h0, exp_nmi});
      do_rld = ($urandom % 40) == 0;
      t      = ($urandom % 3) == 0;
      tick   = t;
      wr_en  = do_rld;
      addr   = do_rld ? A_CTRL : A_CNT;
      wdata  = 16'h000D;
      was_ctrl = do_rld;
      if (do_rld) begin
        exp_nmi = 1'b0;
        exp = 16'd12;
      end else begin
        exp_nmi = t && (exp == 16'd1);
        exp = next_cnt(exp, 1'b1, t);
      end
    end
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R7 random no rst_req", {15'h0, rst_req}, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule